// File: doc/BRIEF.md
# Multiplexed LCD Common and Segment Sequencer

This block produces the time-multiplexed drive pattern for a passive LCD panel. A tick enable, derived from a divided oscillator, paces a small prescaler. The prescaler steps a common-phase counter through three or four phases per frame. In every phase the block outputs a 2-bit level code for each common line and each segment line. An analog stage outside this block turns each code into a voltage.

The selected common and the segments whose display bit is set are driven to opposite extremes. Unselected commons and unlit segments sit at intermediate levels. The bias setting decides which intermediate levels are used. The polarity of the whole pattern flips every frame, so the panel never sees a DC component.

All settings are plain inputs and can change while the block runs. These are the number of commons, the bias, the phase length, blanking, a low-power hold, and a per-pin choice between segment drive and a static port output. The display bits stay outside the block and are never modified by it.

Top module: `lcd_mux_seq`

## Requirements
- R1: `phase` advances by one at the end of each phase period and wraps to 0 after phase 3 when `duty4`=1, or after phase 2 when `duty4`=0. A value above the last phase, left over from a duty change, also wraps to 0 at the next phase end.
- R2: A phase lasts 2^`frate` cycles in which `tick`=1. Cycles with `tick`=0 do not advance the prescaler.
- R3: `frame_pol` toggles exactly when `phase` wraps to 0.
- R4: Level codes are 0=VSS, 1=one-third level (the midpoint level in half bias), 2=two-thirds level, 3=full level. Common c occupies `com_lvl[2c+1:2c]`. The selected common is 3 when `frame_pol`=0 and 0 when `frame_pol`=1. With `bias3`=1, unselected commons are 1 when `frame_pol`=0 and 2 when `frame_pol`=1. With `bias3`=0, unselected commons are always 1.
- R5: When `duty4`=0, common 3 is never selected and always shows the unselected level.
- R6: Segment s takes display bit `disp[4s+phase]` and drives `seg_lvl[2s+1:2s]`. With `frame_pol`=0, a set bit gives 0 and a clear bit gives 2 (`bias3`=1) or 3 (`bias3`=0). With `frame_pol`=1, a set bit gives 3 and a clear bit gives 1 (`bias3`=1) or 0 (`bias3`=0).
- R7: While `blank`=1, every segment shows the level of a clear bit. `disp` is not altered.
- R8: While `sleep`=1, every common and every non-port segment outputs 0, and the prescaler, `phase` and `frame_pol` hold their values.
- R9: For s < NPORT with `port_en[s]`=1, segment s outputs 3 if `port_val[s]`=1 and 0 otherwise. This holds regardless of `sleep` or `blank`.
- R10: After reset, `phase`=0, `frame_pol`=0 and the prescaler is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Divided-oscillator enable |
| duty4 | input | 1 | 1: four commons, 0: three commons |
| bias3 | input | 1 | 1: third bias, 0: half bias |
| frate | input | FRW | Phase length select, 2^frate ticks |
| blank | input | 1 | Force all segments unlit |
| sleep | input | 1 | Low-power hold |
| port_en | input | NPORT | Per-pin port mode for the low segments |
| port_val | input | NPORT | Port output values |
| disp | input | 4*NSEG | Display bits, 4 per segment |
| com_lvl | output | 8 | Common level codes |
| seg_lvl | output | 2*NSEG | Segment level codes |
| phase | output | 2 | Active common index |
| frame_pol | output | 1 | Current frame polarity |

## Verification
The bench builds the block with NSEG=6 and NPORT=2. With these values every segment and both port pins can be compared in every cycle. It sweeps all duty, bias and phase-length combinations with random ticks, random display bits and random port settings. Each run includes a stretch of blanking and a stretch of sleep. Runs follow each other without reset, so a duty change from four to three commons can leave the phase at 3, which reaches the wrap rule in R1.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NSEG  = 16,
  parameter int NPORT = 8,
  parameter int FRW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               duty4,
  input  logic               bias3,
  input  logic [FRW-1:0]     frate,
  input  logic               blank,
  input  logic               sleep,
  input  logic [NPORT-1:0]   port_en,
  input  logic [NPORT-1:0]   port_val,
  input  logic [4*NSEG-1:0]  disp,
  output logic [7:0]         com_lvl,
  output logic [2*NSEG-1:0]  seg_lvl,
  output logic [1:0]         phase,
  output logic               frame_pol
);
  localparam int PW = (1 << FRW) - 1;

  logic [PW-1:0] pcnt;
  logic [PW:0]   plen;
  logic          ph_end, last_com;

  assign plen     = (PW+1)'(1) << frate;
  assign ph_end   = ({1'b0, pcnt} >= plen - (PW+1)'(1));
  assign last_com = duty4 ? (phase == 2'd3) : (phase >= 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      phase     <= 2'd0;
      frame_pol <= 1'b0;
    end else if (tick && !sleep) begin
      if (ph_end) begin
        pcnt <= '0;
        if (last_com) begin
          phase     <= 2'd0;
          frame_pol <= ~frame_pol;
        end else begin
          phase <= phase + 2'd1;
        end
      end else begin
        pcnt <= pcnt + PW'(1);
      end
    end
  end

  logic [1:0] sel_lvl, unsel_lvl, on_lvl, off_lvl;
  assign sel_lvl   = frame_pol ? 2'd0 : 2'd3;
  assign unsel_lvl = (bias3 && frame_pol) ? 2'd2 : 2'd1;
  assign on_lvl    = frame_pol ? 2'd3 : 2'd0;
  assign off_lvl   = frame_pol ? (bias3 ? 2'd1 : 2'd0) : (bias3 ? 2'd2 : 2'd3);

  for (genvar c = 0; c < 4; c++) begin : g_com
    logic sel;
    assign sel = (phase == 2'(c)) && (duty4 || c != 3);
    assign com_lvl[2*c +: 2] = sleep ? 2'd0 : (sel ? sel_lvl : unsel_lvl);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [3:0] row;
    logic [1:0] drv;
    assign row = disp[4*s +: 4];
    assign drv = sleep ? 2'd0 : ((row[phase] && !blank) ? on_lvl : off_lvl);
    if (s < NPORT) begin : g_port
      assign seg_lvl[2*s +: 2] = port_en[s] ? {2{port_val[s]}} : drv;
    end else begin : g_plain
      assign seg_lvl[2*s +: 2] = drv;
    end
  end
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NSEG  = 16,
  parameter int NPORT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              duty4,
  input logic              bias3,
  input logic              blank,
  input logic              sleep,
  input logic [NPORT-1:0]  port_en,
  input logic [NPORT-1:0]  port_val,
  input logic [7:0]        com_lvl,
  input logic [2*NSEG-1:0] seg_lvl,
  input logic [1:0]        phase,
  input logic              frame_pol
);
  logic [NSEG-1:0] np_zero, np_mid, port_ok;
  logic [3:0]      at_sel;

  for (genvar s = 0; s < NSEG; s++) begin : g_s
    logic np;
    logic [1:0] v;
    assign v = seg_lvl[2*s +: 2];
    if (s < NPORT) begin : g_p
      assign np = !port_en[s];
      assign port_ok[s] = np || (v == (port_val[s] ? 2'd3 : 2'd0));
    end else begin : g_n
      assign np = 1'b1;
      assign port_ok[s] = 1'b1;
    end
    assign np_zero[s] = !np || v == 2'd0;
    assign np_mid[s]  = !np || (v == 2'd1 || v == 2'd2);
  end

  for (genvar c = 0; c < 4; c++) begin : g_c
    assign at_sel[c] = com_lvl[2*c +: 2] == (frame_pol ? 2'd0 : 2'd3);
  end

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (com_lvl == 8'd0) && (&np_zero));

  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (phase == $past(phase)) && (frame_pol == $past(frame_pol)));

  assert_pol_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pol != $past(frame_pol)) |-> (phase == 2'd0));

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase == 2'd0 || phase == $past(phase) + 2'd1));

  assert_port_rail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    &port_ok);

  assert_blank_unlit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !sleep && bias3) |-> (&np_mid));

  assert_one_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && bias3 && (duty4 || phase != 2'd3)) |-> ($countones(at_sel) == 1));

  assert_com3_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && bias3 && !duty4) |-> !at_sel[3]);
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(.NSEG(NSEG), .NPORT(NPORT)) u_chk (.*);

// File: tb/lcd_mux_seq_test.sv
module lcd_mux_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG  = 6;
  localparam int NPORT = 2;
  localparam int FRW   = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, duty4 = 1'b0, bias3 = 1'b0;
  logic [FRW-1:0] frate = '0;
  logic blank = 1'b0, sleep = 1'b0;
  logic [NPORT-1:0] port_en = '0, port_val = '0;
  logic [4*NSEG-1:0] disp = '0;
  logic [7:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic [1:0] phase;
  logic frame_pol;

  lcd_mux_seq #(.NSEG(NSEG), .NPORT(NPORT), .FRW(FRW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int m_ph = 0, m_pol = 0, m_cnt = 0;
  int n_ph = 0, n_pol = 0, n_cnt = 0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_com(int c);
    bit sel = (c == m_ph) && (duty4 || c != 3);
    if (sleep) return 0;
    if (sel) return m_pol ? 0 : 3;
    return (bias3 && m_pol) ? 2 : 1;
  endfunction

  function automatic int exp_seg(int s);
    bit on;
    if (s < NPORT && port_en[s]) return port_val[s] ? 3 : 0;
    if (sleep) return 0;
    on = disp[4*s + m_ph] && !blank;
    if (m_pol) return on ? 3 : (bias3 ? 1 : 0);
    return on ? 0 : (bias3 ? 2 : 3);
  endfunction

  task automatic check_all();
    chk("R1 R2 phase", phase, m_ph);
    chk("R3 polarity", frame_pol, m_pol);
    for (int c = 0; c < 4; c++)
      chk(sleep ? "R8 com" : (c == 3 && !duty4) ? "R5 com3" : "R4 com",
          com_lvl[2*c +: 2], exp_com(c));
    for (int s = 0; s < NSEG; s++)
      chk((s < NPORT && port_en[s]) ? "R9 port" : sleep ? "R8 seg" :
          blank ? "R7 seg" : "R6 seg", seg_lvl[2*s +: 2], exp_seg(s));
  endtask

  task automatic model_next();
    int plen = 1 << frate;
    bit lastc;
    n_ph = m_ph; n_pol = m_pol; n_cnt = m_cnt;
    if (tick && !sleep) begin
      if (m_cnt >= plen - 1) begin
        n_cnt = 0;
        lastc = duty4 ? (m_ph == 3) : (m_ph >= 2);
        n_ph = lastc ? 0 : m_ph + 1;
        if (lastc) n_pol = 1 - m_pol;
      end else n_cnt = m_cnt + 1;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 phase", phase, 0);
    chk("R10 polarity", frame_pol, 0);
    chk("R10 com0", com_lvl[1:0], 3);
    rst_n = 1'b1;
    for (int run = 0; run < 32; run++) begin
      duty4 = run[0];
      bias3 = run[1];
      frate = run[3:2];
      port_en = NPORT'($urandom);
      disp = (4*NSEG)'({$urandom, $urandom});
      model_next();
      for (int cyc = 0; cyc < 120; cyc++) begin
        @(negedge clk);
        m_ph = n_ph; m_pol = n_pol; m_cnt = n_cnt;
        check_all();
        tick  = run[4] ? 1'b1 : ($urandom % 3 != 0);
        blank = (cyc >= 40 && cyc < 55);
        sleep = (cyc >= 70 && cyc < 90);
        port_val = NPORT'($urandom);
        if (cyc % 37 == 0) disp = (4*NSEG)'({$urandom, $urandom});
        model_next();
      end
    end
    @(negedge clk);
    m_ph = n_ph; m_pol = n_pol; m_cnt = n_cnt;
    check_all();
    finish_up();
  end
endmodule